// File: doc/BRIEF.md
# Keyed Write-Unlock Sequence Guard

This block guards a diagnostic control register against stray writes. The diagnostic register accepts writes only after software has written a fixed, ordered key of five 4-bit values into the low nibble of a separate sequence register. A small matcher follows the progress through the key. Any wrong nibble sends the matcher back to the start. A correct final nibble opens the diagnostic register for writing.

Once the register is open, it stays open until the sequence register is written again. That write locks it, whatever value it carries. The open/closed state is visible to software as a read-only status bit inside the diagnostic register. All other diagnostic bits are plain storage. Access goes through one register port: a write strobe with an address and data, and a combinational read-data path selected by the same address.

Top module: `keyguard_top`

## Requirements
- R1: After reset the register is locked, the status bit (bit 7 of the diagnostic register at offset 0x008) reads 0, the diagnostic storage reads 0 and the matcher waits for the first key value.
- R2: Writing 0x4, 0xB, 0x2, 0x7, 0xD in that order to bits [3:0] of the sequence register (offset 0x004) unlocks the register. The status bit reads 1 in the cycle after the last write.
- R3: A sequence write whose nibble is not the expected next key value restarts the match from the start. If that nibble equals 0x4, it counts as the first step of a new attempt.
- R4: While unlocked, any write to the sequence register locks the register again. That write is not counted as a key step.
- R5: While locked, writes to the diagnostic register leave its contents unchanged.
- R6: While unlocked, a diagnostic write stores every data bit except the status bit. The status bit is never written and always reflects the lock state.
- R7: The sequence register reads as all zeros, including its key field.
- R8: Only bits [3:0] of a sequence write take part in matching. The upper data bits have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for one cycle |
| regAddr | input | 12 | Byte offset of the register accessed |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |

## Verification
The bench builds the block with its default parameters: 32-bit data, 12-bit offsets, the sequence register at 0x004, the diagnostic register at 0x008 and the status bit at position 7. With these values every step of the five-value key can be reached. Random key writes are biased toward the correct next nibble and carry random upper bits, so full unlocks, partial matches, restarts through a stray 0x4 and relocking writes all occur many times. Directed cases cover a relock whose value is 0x4 and attempts to set the status bit.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

  localparam int KEY_W   = 4;
  localparam int KEY_LEN = 5;
  localparam int STEP_W  = $clog2(KEY_LEN);

  typedef logic [STEP_W-1:0] stepT;
  typedef logic [KEY_W-1:0]  nibT;

  localparam stepT LAST_STEP = stepT'(KEY_LEN - 1);

  // Ordered unlock key, indexed by matcher step.
  function automatic nibT keyAt(stepT idx);
    case (idx)
      stepT'(0): keyAt = 4'h4;
      stepT'(1): keyAt = 4'hB;
      stepT'(2): keyAt = 4'h2;
      stepT'(3): keyAt = 4'h7;
      stepT'(4): keyAt = 4'hD;
      default:   keyAt = 4'h0;
    endcase
  endfunction

  // Strobes from control to datapath.
  typedef struct packed {
    logic diagLoad;  // commit write data to diagnostic storage
    logic selDiag;   // read mux selects the diagnostic register
  } strobeT;

endpackage

// File: rtl/keyguard_ctrl.sv
module keyguard_ctrl
  import keyguard_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] SEQ_ADDR  = 12'h004,
  parameter logic [11:0] DIAG_ADDR = 12'h008
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  nibT               keyNib,
  output strobeT            strobe,
  output logic              unlocked
);

  localparam logic [ADDR_W-1:0] SEQ_A  = ADDR_W'(SEQ_ADDR);
  localparam logic [ADDR_W-1:0] DIAG_A = ADDR_W'(DIAG_ADDR);

  logic seqWr;
  logic diagHit;
  stepT step;
  stepT stepNext;
  logic unlockNext;

  assign seqWr   = regWrEn && (regAddr == SEQ_A);
  assign diagHit = (regAddr == DIAG_A);

  always_comb begin
    stepNext   = step;
    unlockNext = unlocked;
    if (seqWr) begin
      if (unlocked) begin
        // Any sequence write relocks; it is not a key step.
        unlockNext = 1'b0;
        stepNext   = '0;
      end else if (keyNib == keyAt(step)) begin
        if (step == LAST_STEP) begin
          unlockNext = 1'b1;
          stepNext   = '0;
        end else begin
          stepNext = step + stepT'(1);
        end
      end else if (keyNib == keyAt('0)) begin
        stepNext = stepT'(1);
      end else begin
        stepNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step     <= '0;
      unlocked <= 1'b0;
    end else begin
      step     <= stepNext;
      unlocked <= unlockNext;
    end
  end

  assign strobe.diagLoad = regWrEn && diagHit && unlocked;
  assign strobe.selDiag  = diagHit;

  // Relock on any sequence write while open.
  assert_relock_on_seq_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seqWr && unlocked) |=> !unlocked);

  // Opening only follows the last key value at the last step.
  assert_unlock_after_last_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(seqWr && step == LAST_STEP && keyNib == keyAt(LAST_STEP)));

  // A nibble that neither matches nor equals the first key value restarts.
  assert_wrong_nibble_restarts_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqWr && !unlocked && keyNib != keyAt(step) && keyNib != keyAt('0)) |=> (step == '0));

  // The step counter stays within the key length.
  assert_step_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    step <= LAST_STEP);

endmodule

// File: rtl/keyguard_datapath.sv
module keyguard_datapath
  import keyguard_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STATUS_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  localparam logic [DATA_W-1:0] STATUS_MASK = DATA_W'(1) << STATUS_BIT;

  logic [DATA_W-1:0] diagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diagQ <= '0;
    end else if (strobe.diagLoad) begin
      diagQ <= regWrData & ~STATUS_MASK;
    end
  end

  always_comb begin
    regRdData = '0;
    if (strobe.selDiag) begin
      regRdData = (diagQ & ~STATUS_MASK) | (unlocked ? STATUS_MASK : '0);
    end
  end

  // Storage moves only on a gated load strobe.
  assert_locked_storage_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.diagLoad |=> $stable(diagQ));

  // A load strobe never arrives while locked.
  assert_load_requires_unlock_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.diagLoad |-> unlocked);

  // The stored copy never holds the status position.
  assert_status_never_stored_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.diagLoad |=> (diagQ[STATUS_BIT] == 1'b0));

endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
  import keyguard_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] SEQ_ADDR   = 12'h004,
  parameter logic [11:0] DIAG_ADDR  = 12'h008,
  parameter int          STATUS_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  strobeT strobe;
  logic   unlocked;

  keyguard_ctrl #(
    .ADDR_W   (ADDR_W),
    .SEQ_ADDR (SEQ_ADDR),
    .DIAG_ADDR(DIAG_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .keyNib  (regWrData[KEY_W-1:0]),
    .strobe  (strobe),
    .unlocked(unlocked)
  );

  keyguard_datapath #(
    .DATA_W    (DATA_W),
    .STATUS_BIT(STATUS_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .unlocked (unlocked),
    .regWrData(regWrData),
    .regRdData(regRdData)
  );

endmodule

// File: tb/keyguard_top_tb.sv
module keyguard_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] SEQ_A  = 12'h004;
  localparam logic [11:0] DIAG_A = 12'h008;
  localparam logic [31:0] STAT_M = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  int          expStep = 0;
  bit          expEn = 1'b0;
  logic [31:0] expDiag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyguard_top u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [3:0] keyTb(int i);
    case (i)
      0: return 4'h4;
      1: return 4'hB;
      2: return 4'h2;
      3: return 4'h7;
      default: return 4'hD;
    endcase
  endfunction

  function automatic logic [31:0] diagView();
    return (expDiag & ~STAT_M) | (expEn ? STAT_M : 32'h0);
  endfunction

  task automatic modelSeq(logic [31:0] d);
    logic [3:0] n = d[3:0];
    if (expEn) begin
      expEn = 1'b0; expStep = 0;
    end else if (n == keyTb(expStep)) begin
      if (expStep == 4) begin expEn = 1'b1; expStep = 0; end
      else expStep++;
    end else if (n == keyTb(0)) expStep = 1;
    else expStep = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == SEQ_A) modelSeq(d);
    else if (a == DIAG_A && expEn) expDiag = d & ~STAT_M;
  endtask

  task automatic chk(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    #1;
    testsRun++;
    if (regRdData !== exp) begin
      testsFailed++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, regRdData, exp);
    end
  endtask

  task automatic fullKey(logic [27:0] upper);
    for (int i = 0; i < 5; i++) wr(SEQ_A, {upper, keyTb(i)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(DIAG_A, 32'h0, "R1");
    chk(SEQ_A, 32'h0, "R1");

    // R5 locked write ignored
    wr(DIAG_A, 32'hFFFF_FFFF);
    chk(DIAG_A, 32'h0, "R5");

    // R2 full key, R8 with upper bits set
    fullKey(28'hABCDEF1);
    chk(DIAG_A, STAT_M, "R2");
    chk(DIAG_A, diagView(), "R8");

    // R6 status bit not writable, others stored
    wr(DIAG_A, 32'h1234_5678);
    chk(DIAG_A, 32'h1234_56F8 & ~STAT_M | STAT_M, "R6");
    wr(DIAG_A, 32'h0000_0000);
    chk(DIAG_A, STAT_M, "R6");

    // R7 sequence register reads zero while unlocked
    chk(SEQ_A, 32'h0, "R7");

    // R4 relock with value 0x4; not counted as a step
    wr(SEQ_A, 32'h4);
    chk(DIAG_A, diagView(), "R4");
    wr(SEQ_A, 32'hB); wr(SEQ_A, 32'h2); wr(SEQ_A, 32'h7); wr(SEQ_A, 32'hD);
    chk(DIAG_A, 32'h0, "R4");

    // R3 stray 0x4 mid-sequence restarts as first step
    wr(SEQ_A, 32'h4); wr(SEQ_A, 32'hB); wr(SEQ_A, 32'h4);
    wr(SEQ_A, 32'hB); wr(SEQ_A, 32'h2); wr(SEQ_A, 32'h7); wr(SEQ_A, 32'hD);
    chk(DIAG_A, diagView(), "R3");
    chk(DIAG_A, STAT_M, "R3");

    // R3 wrong nibble restarts to zero
    wr(SEQ_A, 32'h0);
    wr(SEQ_A, 32'h4); wr(SEQ_A, 32'hB); wr(SEQ_A, 32'h9);
    wr(SEQ_A, 32'h2); wr(SEQ_A, 32'h7); wr(SEQ_A, 32'hD);
    chk(DIAG_A, 32'h0, "R3");

    // R8 upper bits alone do not match
    wr(SEQ_A, 32'h0000_0040);
    chk(DIAG_A, diagView(), "R8");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] d = $urandom();
      if (op < 6) begin
        if ($urandom_range(0, 9) < 8) d[3:0] = keyTb(expStep);
        wr(SEQ_A, d);
        chk(DIAG_A, diagView(), "R3");
      end else if (op < 9) begin
        wr(DIAG_A, d);
        chk(DIAG_A, diagView(), expEn ? "R6" : "R5");
      end else begin
        chk(SEQ_A, 32'h0, "R7");
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule